// File: doc/BRIEF.md
# Controller Reset Sequencer

This block merges the four reset sources of a disk controller core into the reset outputs the core needs. The sources are a power-on reset, an external hardware reset pin, a host-written reset bit in the output control register, and a host-written reset bit in the data-rate register. The block drives three resets. The first is a level reset for the core state machine and FIFO. The second is a register reset that clears every register except the drive timing parameters. The third is a timing-parameter reset, which only power-on raises. The block also gives two one-cycle strobes. One wakes the core from power-down whenever a reset starts. The other clears the stored configuration settings and restarts drive polling when reset ends.

The two software reset bits differ. The output-register bit is active low and stays where the host writes it. The data-rate bit starts a fixed countdown and then clears itself. The hardware pin, passed through a synchronizer, forces the output-register bit into its reset state. After the pin is released, the core therefore stays in reset until the host writes that bit back to 1. The host writes each register bit through its own write strobe and data bit. The current value of each bit can be read back.

Top module: `ctrl_reset_seq`

## Requirements
- R1: While `porN` is low, `coreRst`, `regRst`, `timingRst` and `wakeUp` are 1, and `cfgClr`, `outRstBitRd` and `rateRstBitRd` are 0. `timingRst` falls on the first clock edge after `porN` rises, and `outRstBitRd` stays 0, so the core stays in reset.
- R2: The pin reset works as follows. A low `hwRstN` raises `regRst` and `coreRst` on the 3rd clock edge after the pin falls, with `SYNC_STAGES`=2. When the pin goes high again, `regRst` drops on the 3rd edge after that. `timingRst` is unaffected.
- R3: While the synchronized pin reset is active, `outRstBitRd` is forced to 0 and host writes to it are ignored. After the pin is released, `coreRst` stays 1 until the host writes the bit to 1.
- R4: The output-register reset bit is active low. A write with `outWrBit`=0 shows on `outRstBitRd` after the strobe edge and raises `coreRst` one edge later. A write with 1 releases `coreRst` one edge after the readback changes.
- R5: A data-rate write with `rateWrBit`=1 makes `rateRstBitRd` read 1 for `RATE_HOLD` (4) cycles, starting at the strobe edge. It holds `coreRst` at 1 for exactly `RATE_HOLD` cycles, starting one edge later. A write with 0 has no effect.
- R6: When the output-register reset is asserted, a data-rate reset that expires does not release `coreRst` and produces no `cfgClr`.
- R7: `wakeUp` is a one-cycle pulse in the cycle `coreRst` rises from any source.
- R8: `cfgClr` is a one-cycle pulse in the cycle `coreRst` falls.
- R9: Software resets never raise `regRst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| hwRstN | input | 1 | External hardware reset pin, active low |
| outWrEn | input | 1 | Write strobe for the output-register reset bit |
| outWrBit | input | 1 | Value written to that bit (0 = reset) |
| rateWrEn | input | 1 | Write strobe for the data-rate reset bit |
| rateWrBit | input | 1 | Value written to that bit (1 = start reset) |
| coreRst | output | 1 | Core reset level |
| regRst | output | 1 | Reset for all registers except timing parameters |
| timingRst | output | 1 | Reset for timing parameters (power-on only) |
| wakeUp | output | 1 | One-cycle pulse: leave power-down |
| cfgClr | output | 1 | One-cycle pulse: clear configuration, restart polling |
| outRstBitRd | output | 1 | Readback of the output-register reset bit |
| rateRstBitRd | output | 1 | Readback of the data-rate reset bit |

## Verification
The bench drives each reset source on its own, then overlaps them. Power-on alone shows the hard reset state and the held output-register bit. A write of 0 and then 1 to the output bit tells a latched release from the data-rate countdown, which the bench times cycle by cycle. A pin pulse with a write during it shows that the pin overrides the host and that `regRst` is kept for hard resets. A data-rate reset started under a held output reset shows which source takes precedence.

// File: rtl/ctrl_reset_pkg.sv
package ctrl_reset_pkg;
  // Reset requests from the control side, one per source.
  typedef struct packed {
    logic pinHold;
    logic outHold;
    logic rateHold;
  } rstReq_t;
endpackage

// File: rtl/ctrl_reset_ctrl.sv
module ctrl_reset_ctrl
  import ctrl_reset_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RATE_HOLD   = 4
) (
  input  logic    clk,
  input  logic    porN,
  input  logic    hwRstN,
  input  logic    outWrEn,
  input  logic    outWrBit,
  input  logic    rateWrEn,
  input  logic    rateWrBit,
  output rstReq_t req,
  output logic    outBit,
  output logic    rateBusy
);
  localparam int CNT_W = $clog2(RATE_HOLD + 1);

  logic [SYNC_STAGES-1:0] pinSync;
  logic [CNT_W-1:0]       rateCnt;

  // Pin synchronizer; held in reset while power-on is active.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge porN)
        if (!porN) pinSync <= '1;
        else       pinSync <= ~hwRstN;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge porN)
        if (!porN) pinSync <= '1;
        else       pinSync <= {pinSync[SYNC_STAGES-2:0], ~hwRstN};
    end
  endgenerate

  // Latched, active-low output-register reset bit; the pin forces it low.
  always_ff @(posedge clk or negedge porN)
    if (!porN)                     outBit <= 1'b0;
    else if (pinSync[SYNC_STAGES-1]) outBit <= 1'b0;
    else if (outWrEn)              outBit <= outWrBit;

  // Self-clearing data-rate reset: a countdown started by a write of 1.
  always_ff @(posedge clk or negedge porN)
    if (!porN)                     rateCnt <= '0;
    else if (rateWrEn && rateWrBit) rateCnt <= CNT_W'(RATE_HOLD);
    else if (rateCnt != '0)        rateCnt <= rateCnt - CNT_W'(1);

  assign rateBusy     = (rateCnt != '0);
  assign req.pinHold  = pinSync[SYNC_STAGES-1];
  assign req.outHold  = ~outBit;
  assign req.rateHold = rateBusy;
endmodule

// File: rtl/ctrl_reset_path.sv
module ctrl_reset_path
  import ctrl_reset_pkg::*;
(
  input  logic    clk,
  input  logic    porN,
  input  rstReq_t req,
  output logic    coreRst,
  output logic    regRst,
  output logic    timingRst,
  output logic    wakeUp,
  output logic    cfgClr
);
  logic coreNext;

  // The latched output reset dominates simply by being an OR term that
  // outlives the countdown.
  assign coreNext = req.pinHold | req.outHold | req.rateHold;

  always_ff @(posedge clk or negedge porN)
    if (!porN) begin
      coreRst   <= 1'b1;
      regRst    <= 1'b1;
      timingRst <= 1'b1;
      wakeUp    <= 1'b1;
      cfgClr    <= 1'b0;
    end else begin
      coreRst   <= coreNext;
      regRst    <= req.pinHold;
      timingRst <= 1'b0;
      wakeUp    <= coreNext & ~coreRst;
      cfgClr    <= ~coreNext & coreRst;
    end
endmodule

// File: rtl/ctrl_reset_seq.sv
module ctrl_reset_seq
  import ctrl_reset_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RATE_HOLD   = 4
) (
  input  logic clk,
  input  logic porN,
  input  logic hwRstN,
  input  logic outWrEn,
  input  logic outWrBit,
  input  logic rateWrEn,
  input  logic rateWrBit,
  output logic coreRst,
  output logic regRst,
  output logic timingRst,
  output logic wakeUp,
  output logic cfgClr,
  output logic outRstBitRd,
  output logic rateRstBitRd
);
  rstReq_t req;

  ctrl_reset_ctrl #(.SYNC_STAGES(SYNC_STAGES), .RATE_HOLD(RATE_HOLD)) i_ctrl (
    .clk      (clk),
    .porN     (porN),
    .hwRstN   (hwRstN),
    .outWrEn  (outWrEn),
    .outWrBit (outWrBit),
    .rateWrEn (rateWrEn),
    .rateWrBit(rateWrBit),
    .req      (req),
    .outBit   (outRstBitRd),
    .rateBusy (rateRstBitRd)
  );

  ctrl_reset_path i_path (
    .clk      (clk),
    .porN     (porN),
    .req      (req),
    .coreRst  (coreRst),
    .regRst   (regRst),
    .timingRst(timingRst),
    .wakeUp   (wakeUp),
    .cfgClr   (cfgClr)
  );
endmodule

// File: rtl/ctrl_reset_chk.sv
module ctrl_reset_chk (
  input logic clk,
  input logic porN,
  input logic coreRst,
  input logic regRst,
  input logic timingRst,
  input logic wakeUp,
  input logic cfgClr,
  input logic outRstBitRd,
  input logic rateRstBitRd
);
  // R1: the timing reset only coexists with a full hard reset
  a_r1_timing_with_hard: assert property (@(posedge clk) disable iff (!porN)
    timingRst |-> (coreRst && regRst));

  // R3: a pin-driven register reset keeps the output bit in reset
  a_r3_pin_forces_out: assert property (@(posedge clk) disable iff (!porN)
    regRst |-> !outRstBitRd);

  // R4: the output bit falling puts the core in reset next cycle
  a_r4_out_asserts: assert property (@(posedge clk) disable iff (!porN)
    $fell(outRstBitRd) |=> coreRst);

  // R5: while the rate countdown runs the core is in reset next cycle
  a_r5_rate_holds: assert property (@(posedge clk) disable iff (!porN)
    rateRstBitRd |=> coreRst);

  // R7: wake strobe accompanies every rise and lasts one cycle
  a_r7_wake_on_rise: assert property (@(posedge clk) disable iff (!porN)
    $rose(coreRst) |-> wakeUp);
  a_r7_wake_single: assert property (@(posedge clk) disable iff (!porN)
    wakeUp |=> !wakeUp);

  // R8: configuration clear accompanies every fall and lasts one cycle
  a_r8_clear_on_fall: assert property (@(posedge clk) disable iff (!porN)
    $fell(coreRst) |-> cfgClr);
  a_r8_clear_single: assert property (@(posedge clk) disable iff (!porN)
    cfgClr |=> !cfgClr);
endmodule

bind ctrl_reset_seq ctrl_reset_chk i_chk (
  .clk         (clk),
  .porN        (porN),
  .coreRst     (coreRst),
  .regRst      (regRst),
  .timingRst   (timingRst),
  .wakeUp      (wakeUp),
  .cfgClr      (cfgClr),
  .outRstBitRd (outRstBitRd),
  .rateRstBitRd(rateRstBitRd)
);

// File: tb/test_ctrl_reset_seq.sv
`timescale 1ns/1ps
module test_ctrl_reset_seq;
  logic clk = 1'b0;
  logic porN = 1'b0, hwRstN = 1'b1;
  logic outWrEn = 1'b0, outWrBit = 1'b0, rateWrEn = 1'b0, rateWrBit = 1'b0;
  logic coreRst, regRst, timingRst, wakeUp, cfgClr, outRstBitRd, rateRstBitRd;

  always #2 clk = ~clk;

  ctrl_reset_seq i_ctrl_reset_seq (
    .clk(clk), .porN(porN), .hwRstN(hwRstN),
    .outWrEn(outWrEn), .outWrBit(outWrBit),
    .rateWrEn(rateWrEn), .rateWrBit(rateWrBit),
    .coreRst(coreRst), .regRst(regRst), .timingRst(timingRst),
    .wakeUp(wakeUp), .cfgClr(cfgClr),
    .outRstBitRd(outRstBitRd), .rateRstBitRd(rateRstBitRd)
  );

  // observed vector bit positions
  localparam logic [6:0] M_CORE = 7'h01, M_REG = 7'h02, M_TIM = 7'h04,
                         M_WAKE = 7'h08, M_CFG = 7'h10, M_OUT = 7'h20, M_RATE = 7'h40;

  typedef struct { string req; logic [6:0] mask; logic [6:0] val; } sbItem_t;
  sbItem_t sbQ[$];
  int checks = 0, fails = 0;
  bit done = 0;

  wire [6:0] obs = {rateRstBitRd, outRstBitRd, cfgClr, wakeUp, timingRst, regRst, coreRst};

  task automatic tick(); @(negedge clk); endtask

  task automatic expectNow(string req, logic [6:0] mask, logic [6:0] val);
    sbItem_t it;
    it.req = req; it.mask = mask; it.val = val;
    sbQ.push_back(it);
  endtask

  task automatic writeOut(logic b);
    outWrEn = 1'b1; outWrBit = b;
    tick();
    outWrEn = 1'b0;
  endtask

  task automatic writeRate(logic b);
    rateWrEn = 1'b1; rateWrBit = b;
    tick();
    rateWrEn = 1'b0;
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (sbQ.size() > 0) begin
      sbItem_t it;
      it = sbQ.pop_front();
      checks++;
      if ((obs & it.mask) !== it.val) begin
        fails++;
        $display("FAIL %s: actual=%b expected=%b (mask %b)", it.req, obs & it.mask, it.val, it.mask);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R1: power-on state
    tick(); tick();
    expectNow("R1", 7'h7F, M_CORE | M_REG | M_TIM | M_WAKE);
    tick();
    porN = 1'b1;
    tick();
    expectNow("R1", M_CORE | M_TIM | M_WAKE, M_CORE);
    tick(); tick();
    expectNow("R1", M_CORE | M_REG | M_OUT, M_CORE);

    // R4/R8: release through the output bit
    writeOut(1'b1);
    expectNow("R4", M_CORE | M_OUT, M_CORE | M_OUT);
    tick();
    expectNow("R8", M_CORE | M_CFG, M_CFG);
    tick();
    expectNow("R8", M_CORE | M_CFG | M_WAKE, 7'h00);

    // R4/R7/R9: assert via the output bit
    writeOut(1'b0);
    expectNow("R4", M_CORE | M_OUT | M_RATE, 7'h00);
    tick();
    expectNow("R7", M_CORE | M_WAKE | M_REG, M_CORE | M_WAKE);
    tick();
    expectNow("R7", M_CORE | M_WAKE, M_CORE);
    writeOut(1'b1);
    expectNow("R4", M_OUT | M_CORE, M_OUT | M_CORE);
    tick();
    expectNow("R4", M_CORE | M_CFG, M_CFG);
    tick();

    // R5: self-clearing data-rate reset, 4 cycles
    writeRate(1'b1);
    expectNow("R5", M_RATE | M_CORE, M_RATE);
    tick();
    expectNow("R5", M_CORE | M_WAKE | M_RATE, M_CORE | M_WAKE | M_RATE);
    tick();
    expectNow("R9", M_CORE | M_REG | M_RATE | M_WAKE, M_CORE | M_RATE);
    tick();
    expectNow("R5", M_CORE | M_RATE, M_CORE | M_RATE);
    tick();
    expectNow("R5", M_CORE | M_RATE, M_CORE);
    tick();
    expectNow("R5", M_CORE | M_CFG | M_OUT, M_CFG | M_OUT);
    tick();

    // R5: writing 0 to the data-rate bit does nothing
    writeRate(1'b0);
    expectNow("R5", M_RATE, 7'h00);
    tick(); tick();
    expectNow("R5", M_CORE | M_WAKE | M_RATE, 7'h00);

    // R6: output reset dominates an expiring data-rate reset
    writeOut(1'b0);
    tick();
    expectNow("R6", M_CORE, M_CORE);
    writeRate(1'b1);
    expectNow("R6", M_RATE | M_CORE, M_RATE | M_CORE);
    repeat (5) tick();
    expectNow("R6", M_CORE | M_CFG | M_RATE, M_CORE);
    tick();
    expectNow("R6", M_CORE | M_CFG, M_CORE);
    writeOut(1'b1);
    tick();
    expectNow("R6", M_CORE | M_CFG, M_CFG);
    tick();

    // R2/R3: hardware pin reset
    hwRstN = 1'b0;
    tick();
    expectNow("R2", M_CORE | M_REG, 7'h00);
    tick();
    expectNow("R2", M_CORE | M_REG, 7'h00);
    tick();
    expectNow("R2", M_CORE | M_REG | M_WAKE | M_OUT | M_TIM, M_CORE | M_REG | M_WAKE);
    writeOut(1'b1);
    expectNow("R3", M_OUT, 7'h00);
    hwRstN = 1'b1;
    tick(); tick();
    expectNow("R2", M_REG | M_CORE, M_REG | M_CORE);
    tick();
    expectNow("R3", M_REG | M_CORE | M_OUT | M_TIM, M_CORE);
    tick(); tick();
    expectNow("R3", M_CORE | M_CFG, M_CORE);
    writeOut(1'b1);
    expectNow("R3", M_OUT | M_CORE, M_OUT | M_CORE);
    tick();
    expectNow("R3", M_CORE | M_CFG, M_CFG);
    tick(); tick();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule